// File: doc/BRIEF.md
# Legacy Serial Resource Auto-Configurator

This block owns the resource setting of an ISA-style serial port function. A local microcontroller loads one 8-bit configuration word and can read it back. That word chooses one of eight 8-byte host I/O windows and one of eight host interrupt lines. While the jumper-mode bit of the word is set, the block decodes host addresses into a chip select for the serial core. It also steers the serial core's interrupt onto the chosen host line as a one-hot routing vector.

The host can change the window or line selection through a narrow configuration strobe. If it does so while jumper mode is active, the block raises a save-request bit. Firmware then writes the setting to non-volatile storage as the next power-on default, and clears the bit by writing the word.

The block also watches host writes to the Plug-and-Play address port. When a host sends the complete initiation key there, jumper mode is cancelled so that the Plug-and-Play logic can take over the resources.

Top module: `serial_autocfg`

## Requirements
- R1: After reset the read-back word `mcu_rdata` is `{1'b0, 1'b0, DEFAULT_SEL}`. Bit 7 is the jumper-mode enable, bit 6 is the save request, bits 5:3 are the window code and bits 2:0 are the interrupt code. `cs` and `irq_route` are zero.
- R2: A microcontroller write (`mcu_wr`) loads all eight bits from `mcu_wdata`, and the new value is read back on the next cycle.
- R3: `cs` is high exactly when jumper mode is on and `host_addr[15:3]` equals bits 15:3 of the selected base. The window codes 0 to 7 map to bases 3F8h, 2F8h, 3E8h, 2E8h, 3F0h, 2F0h, 3E0h and 2E0h.
- R4: `irq_route[i]` is high exactly when jumper mode is on, `uart_irq` is high and the interrupt code equals i. Codes 0 to 7 stand for host lines 3, 4, 5, 7, 10, 11, 12 and 15.
- R5: Host writes of the 32 key bytes, in order, to port 279h clear bit 7 on the edge of the last byte. Bits 6:0 are left unchanged. The key starts at 6Ah, and each next byte is `{b0^b1, b7:1}` of the previous one.
- R6: A key-port write whose byte differs from the expected byte sends the comparison back to the start, so the next key-port write is compared with 6Ah. Host writes to other addresses do not affect the comparison.
- R7: A host configuration write (`host_cfg_wr`) replaces the window code when `host_cfg_io` is 1 and the interrupt code when it is 0. It sets bit 6 only if jumper mode was on before the write.
- R8: A microcontroller write with bit 6 at 0 clears the save request. A host configuration write in jumper mode during the same cycle still leaves bit 6 set.
- R9: When a microcontroller write with bit 7 at 1 falls in the same cycle as the completing key byte, bit 7 ends at 0.
- R10: When a microcontroller write and a host configuration write fall in the same cycle, bits 5:0 take the microcontroller's value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcu_wr | input | 1 | Microcontroller write strobe |
| mcu_wdata | input | 8 | Microcontroller write data |
| mcu_rdata | output | 8 | Current configuration word |
| host_wr | input | 1 | Host I/O write strobe |
| host_addr | input | ADDR_W | Host I/O address |
| host_wdata | input | 8 | Host I/O write data |
| host_cfg_wr | input | 1 | Host configuration change strobe |
| host_cfg_io | input | 1 | 1: change window code, 0: change interrupt code |
| host_cfg_val | input | 3 | New code |
| uart_irq | input | 1 | Serial core interrupt request |
| cs | output | 1 | Serial core chip select |
| irq_route | output | 8 | One-hot host interrupt routing |

## Verification
The hardest situation to reach is the key detector at the edge of completing, or just after it has been knocked back. The bench drives keys that break off at byte 11, keys interleaved with writes to unrelated ports, and a key whose final byte coincides with a firmware write that sets jumper mode. After each case it confirms through the read-back word whether bit 7 survived.

// File: rtl/serial_autocfg_pkg.sv
package serial_autocfg_pkg;

   localparam int CODE_W = 3;
   localparam int NUM_SEL = 1 << CODE_W;

   typedef struct packed {
      logic                jump;
      logic                save;
      logic [CODE_W-1:0]   io;
      logic [CODE_W-1:0]   irq;
   } acfg_t;

   // Base of each 8-byte window: each code bit strips a fixed offset from 3F8h.
   function automatic logic [15:0] win_base(input logic [CODE_W-1:0] code);
      logic [15:0] b;
      b = 16'h03F8;
      if (code[0]) b = b - 16'h0100;
      if (code[1]) b = b - 16'h0010;
      if (code[2]) b = b - 16'h0008;
      return b;
   endfunction

   function automatic logic [7:0] key_step(input logic [7:0] v);
      return {v[1] ^ v[0], v[7:1]};
   endfunction

endpackage

// File: rtl/sac_key_detect.sv
module sac_key_detect
   import serial_autocfg_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter logic [15:0] KEY_PORT = 16'h0279,
   parameter logic [7:0]  KEY_SEED = 8'h6A,
   parameter int          KEY_LEN  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        data,
   output logic              hit
);
   localparam int CW = (KEY_LEN > 2) ? $clog2(KEY_LEN) : 1;
   localparam logic [CW-1:0] LAST = CW'(KEY_LEN - 1);

   logic [CW-1:0] idx_q;
   logic [7:0]    exp_q;
   logic          port_wr, match;

   assign port_wr = wr && (addr == ADDR_W'(KEY_PORT));
   assign match   = (data == exp_q);
   assign hit     = port_wr && match && (idx_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         exp_q <= KEY_SEED;
      end else if (port_wr) begin
         if (match && idx_q != LAST) begin
            idx_q <= idx_q + 1'b1;
            exp_q <= key_step(exp_q);
         end else begin
            idx_q <= '0;
            exp_q <= KEY_SEED;
         end
      end
   end

   assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr && !match) |=> (exp_q == KEY_SEED && idx_q == '0));
   assert_other_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !port_wr |=> $stable(idx_q));

endmodule

// File: rtl/sac_cfg_reg.sv
module sac_cfg_reg
   import serial_autocfg_pkg::*;
#(
   parameter logic [5:0] DEFAULT_SEL = 6'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mcu_wr,
   input  logic [7:0]        mcu_wdata,
   input  logic              host_cfg_wr,
   input  logic              host_cfg_io,
   input  logic [CODE_W-1:0] host_cfg_val,
   input  logic              key_hit,
   output acfg_t             cfg
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.jump <= 1'b0;
         cfg.save <= 1'b0;
         cfg.io   <= DEFAULT_SEL[5:3];
         cfg.irq  <= DEFAULT_SEL[2:0];
      end else begin
         if (mcu_wr) begin
            cfg.jump <= mcu_wdata[7];
            cfg.save <= mcu_wdata[6];
            cfg.io   <= mcu_wdata[5:3];
            cfg.irq  <= mcu_wdata[2:0];
         end else if (host_cfg_wr) begin
            if (host_cfg_io) cfg.io  <= host_cfg_val;
            else             cfg.irq <= host_cfg_val;
         end
         if (host_cfg_wr && cfg.jump) cfg.save <= 1'b1;
         if (key_hit) cfg.jump <= 1'b0;
      end
   end

   assert_key_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      key_hit |=> !cfg.jump);
   assert_save_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_cfg_wr && cfg.jump) |=> cfg.save);
   assert_mcu_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mcu_wr |=> ({cfg.io, cfg.irq} == $past(mcu_wdata[5:0])));
   assert_key_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (key_hit && !mcu_wr && !host_cfg_wr) |=> $stable({cfg.save, cfg.io, cfg.irq}));

endmodule

// File: rtl/sac_decode.sv
module sac_decode
   import serial_autocfg_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int WIN_LOG = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               jump,
   input  logic [CODE_W-1:0]  io_code,
   input  logic [CODE_W-1:0]  irq_code,
   input  logic [ADDR_W-1:0]  host_addr,
   input  logic               uart_irq,
   output logic               cs,
   output logic [NUM_SEL-1:0] irq_route
);
   logic [ADDR_W-1:0] base;

   assign base = ADDR_W'(win_base(io_code));
   assign cs   = jump && (host_addr[ADDR_W-1:WIN_LOG] == base[ADDR_W-1:WIN_LOG]);

   for (genvar i = 0; i < NUM_SEL; i++) begin : g_route
      assign irq_route[i] = jump && uart_irq && (irq_code == CODE_W'(i));
   end

   assert_route_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_route));
   assert_cs_needs_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cs |-> jump);
   assert_route_needs_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_route != '0) |-> (uart_irq && jump));

endmodule

// File: rtl/serial_autocfg.sv
module serial_autocfg
   import serial_autocfg_pkg::*;
#(
   parameter int          ADDR_W      = 16,
   parameter logic [5:0]  DEFAULT_SEL = 6'h00,
   parameter logic [15:0] KEY_PORT    = 16'h0279,
   parameter logic [7:0]  KEY_SEED    = 8'h6A,
   parameter int          KEY_LEN     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mcu_wr,
   input  logic [7:0]        mcu_wdata,
   output logic [7:0]        mcu_rdata,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [7:0]        host_wdata,
   input  logic              host_cfg_wr,
   input  logic              host_cfg_io,
   input  logic [2:0]        host_cfg_val,
   input  logic              uart_irq,
   output logic              cs,
   output logic [7:0]        irq_route
);
   localparam int WIN_LOG = 3;

   if (ADDR_W < 10) begin : g_bad_addr
      $error("serial_autocfg: ADDR_W must be at least 10");
   end
   if (KEY_LEN < 2) begin : g_bad_key
      $error("serial_autocfg: KEY_LEN must be at least 2");
   end

   acfg_t cfg;
   logic  key_hit;

   sac_key_detect #(
      .ADDR_W(ADDR_W), .KEY_PORT(KEY_PORT), .KEY_SEED(KEY_SEED), .KEY_LEN(KEY_LEN)
   ) u_key (
      .clk(clk), .rst_n(rst_n), .wr(host_wr), .addr(host_addr),
      .data(host_wdata), .hit(key_hit)
   );

   sac_cfg_reg #(.DEFAULT_SEL(DEFAULT_SEL)) u_cfg (
      .clk(clk), .rst_n(rst_n), .mcu_wr(mcu_wr), .mcu_wdata(mcu_wdata),
      .host_cfg_wr(host_cfg_wr), .host_cfg_io(host_cfg_io),
      .host_cfg_val(host_cfg_val), .key_hit(key_hit), .cfg(cfg)
   );

   sac_decode #(.ADDR_W(ADDR_W), .WIN_LOG(WIN_LOG)) u_dec (
      .clk(clk), .rst_n(rst_n), .jump(cfg.jump), .io_code(cfg.io),
      .irq_code(cfg.irq), .host_addr(host_addr), .uart_irq(uart_irq),
      .cs(cs), .irq_route(irq_route)
   );

   assign mcu_rdata = cfg;

endmodule

// File: tb/sim_serial_autocfg.sv
module sim_serial_autocfg;
   localparam logic [5:0] DEF = 6'b101_110;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mcu_wr = 1'b0;
   logic [7:0]  mcu_wdata = '0;
   logic [7:0]  mcu_rdata;
   logic        host_wr = 1'b0;
   logic [15:0] host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic        host_cfg_wr = 1'b0;
   logic        host_cfg_io = 1'b0;
   logic [2:0]  host_cfg_val = '0;
   logic        uart_irq = 1'b0;
   logic        cs;
   logic [7:0]  irq_route;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   logic [7:0] key [32];

   always #5 clk = ~clk;

   serial_autocfg #(.DEFAULT_SEL(DEF)) u0 (
      .clk(clk), .rst_n(rst_n), .mcu_wr(mcu_wr), .mcu_wdata(mcu_wdata),
      .mcu_rdata(mcu_rdata), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_cfg_wr(host_cfg_wr), .host_cfg_io(host_cfg_io),
      .host_cfg_val(host_cfg_val), .uart_irq(uart_irq), .cs(cs), .irq_route(irq_route)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         fails = fails + 1;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
         $finish;
      end
   end

   function automatic logic [15:0] ref_base(input int c);
      case (c)
         0: return 16'h03F8;  1: return 16'h02F8;
         2: return 16'h03E8;  3: return 16'h02E8;
         4: return 16'h03F0;  5: return 16'h02F0;
         6: return 16'h03E0;  default: return 16'h02E0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      tests = tests + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic mcu_write(input logic [7:0] d);
      mcu_wr = 1'b1; mcu_wdata = d;
      @(negedge clk);
      mcu_wr = 1'b0;
   endtask

   task automatic host_write(input logic [15:0] a, input logic [7:0] d);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic cfg_write(input logic io, input logic [2:0] v);
      host_cfg_wr = 1'b1; host_cfg_io = io; host_cfg_val = v;
      @(negedge clk);
      host_cfg_wr = 1'b0;
   endtask

   task automatic send_key(input int first, input int last);
      for (int k = first; k <= last; k++) host_write(16'h0279, key[k]);
   endtask

   initial begin
      key[0] = 8'h6A;
      for (int k = 1; k < 32; k++) key[k] = {key[k-1][1] ^ key[k-1][0], key[k-1][7:1]};

      repeat (3) @(negedge clk);
      uart_irq = 1'b1;
      host_addr = 16'h02F0;
      #1;
      chk("R1 reset word", {8'h0, mcu_rdata}, {8'h0, 2'b00, DEF});
      chk("R1 reset cs", {15'h0, cs}, 16'h0);
      chk("R1 reset route", {8'h0, irq_route}, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 plain load and read-back
      mcu_write(8'h55);
      chk("R2 load 55", {8'h0, mcu_rdata}, 16'h0055);
      mcu_write(8'hAA);
      chk("R2 load AA", {8'h0, mcu_rdata}, 16'h00AA);

      // R3 window decode sweep
      for (int c = 0; c < 8; c++) begin
         mcu_write({2'b10, 3'(c), 3'b000});
         for (int t = 0; t < 8; t++) begin
            host_addr = ref_base(t); #1;
            chk($sformatf("R3 code %0d base of %0d", c, t), {15'h0, cs}, {15'h0, c == t});
         end
         host_addr = ref_base(c) + 16'd7; #1;
         chk("R3 top of window", {15'h0, cs}, 16'h1);
         host_addr = ref_base(c) - 16'd1; #1;
         chk("R3 below window", {15'h0, cs}, 16'h0);
         host_addr = ref_base(c) + 16'd8; #1;
         chk("R3 above window", {15'h0, cs}, 16'h0);
         host_addr = ref_base(c) | 16'h8000; #1;
         chk("R3 upper address bits", {15'h0, cs}, 16'h0);
         mcu_write({2'b00, 3'(c), 3'b000});
         host_addr = ref_base(c); #1;
         chk("R3 jumper off", {15'h0, cs}, 16'h0);
         @(negedge clk);
      end

      // R4 routing sweep
      for (int c = 0; c < 8; c++)
         for (int j = 0; j < 2; j++)
            for (int u = 0; u < 2; u++) begin
               mcu_write({1'(j), 1'b0, 3'b000, 3'(c)});
               uart_irq = 1'(u); #1;
               chk($sformatf("R4 code %0d j %0d u %0d", c, j, u), {8'h0, irq_route},
                   (j == 1 && u == 1) ? (16'h1 << c) : 16'h0);
               @(negedge clk);
            end
      uart_irq = 1'b0;

      // R5 full key
      mcu_write(8'hAD);
      send_key(0, 30);
      chk("R5 31 bytes keep jumper", {8'h0, mcu_rdata}, 16'h00AD);
      send_key(31, 31);
      chk("R5 key clears bit7 only", {8'h0, mcu_rdata}, 16'h002D);

      // R6 broken key then full key interleaved with other ports
      mcu_write(8'h9C);
      send_key(0, 10);
      host_write(16'h0279, 8'h00);
      send_key(11, 31);
      chk("R6 broken key ignored", {8'h0, mcu_rdata}, 16'h009C);
      for (int k = 0; k < 32; k++) begin
         host_write(16'h02F8, 8'h6A);
         host_write(16'h0A79, key[k]);
         host_write(16'h0279, key[k]);
      end
      chk("R6 restart then interleaved key", {8'h0, mcu_rdata}, 16'h001C);

      // R7 host configuration changes
      mcu_write(8'h80);
      cfg_write(1'b1, 3'd3);
      chk("R7 io change sets save", {8'h0, mcu_rdata}, 16'h00D8);
      cfg_write(1'b0, 3'd5);
      chk("R7 irq change", {8'h0, mcu_rdata}, 16'h00DD);
      mcu_write(8'h00);
      cfg_write(1'b1, 3'd7);
      chk("R7 no save when jumper off", {8'h0, mcu_rdata}, 16'h0038);

      // R8 firmware clears save, unless a host change collides
      mcu_write(8'hC0);
      mcu_write(8'h80);
      chk("R8 clear save", {8'h0, mcu_rdata}, 16'h0080);
      mcu_wr = 1'b1; mcu_wdata = 8'h81;
      host_cfg_wr = 1'b1; host_cfg_io = 1'b1; host_cfg_val = 3'd2;
      @(negedge clk);
      mcu_wr = 1'b0; host_cfg_wr = 1'b0;
      chk("R8 R10 collision", {8'h0, mcu_rdata}, 16'h00C1);

      // R9 key wins over firmware enabling jumper
      mcu_write(8'h00);
      send_key(0, 30);
      mcu_wr = 1'b1; mcu_wdata = 8'h8A;
      host_wr = 1'b1; host_addr = 16'h0279; host_wdata = key[31];
      @(negedge clk);
      mcu_wr = 1'b0; host_wr = 1'b0;
      chk("R9 key beats enable", {8'h0, mcu_rdata}, 16'h000A);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule